// File: doc/BRIEF.md
# External Interrupt Request Controller

This block conditions one external interrupt pin and turns its activity into a held interrupt request for a CPU core. The pin is brought into the clock domain through a synchronizer. A detector then looks for the programmed active edge, falling or rising. In the combined mode it also looks for the matching active level. Each hit sets a pending-request latch. A mask bit in the control register gates the latch onto the interrupt output. The mask does not stop the latch from capturing.

The CPU reaches the block through one 8-bit status and control register on a plain register bus with address, write strobe, write data and combinational read data. The latch can be cleared in two ways. Software can write a one to the acknowledge position, or the CPU can pulse a vectoring acknowledge strobe while it processes the exception. Because of this, one pulse on the pin produces exactly one serviced request. The interrupt output takes no account of any global mask held in the CPU.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register bit reads 0, no request is pending and `irq_o` is 0.
- R2: The register is decoded only at address 0x0F. Reads at any other address return 0, and writes at any other address change nothing, including the pending request.
- R3: Bit 0 (active edge: 1 rising, 0 falling), bit 1 (mode: 0 edge only, 1 edge plus level) and bit 2 (mask) are read/write. Bits 7, 5, 4 and 3 always read 0.
- R4: An active edge on `pin_i` sets the pending request. The request is visible on the third rising clock edge after the pin changes, because of the two-flop synchronizer. An edge of the opposite direction sets nothing.
- R5: In edge-only mode, holding the pin at its new level after an acknowledge does not set the request again.
- R6: In edge-plus-level mode, the pin at the active level sets the request on every cycle, so it stays pending through any acknowledge. The active level is low when falling edges are selected and high when rising edges are selected.
- R7: With bit 2 set, `irq_o` stays 0 while the latch still captures requests. Clearing bit 2 exposes a pending request on `irq_o`.
- R8: Bit 6 reads 1 while a request is pending. Writing 1 to bit 6 at 0x0F clears the request, and the written value never reads back. Writing 0 to bit 6 leaves the request unchanged.
- R9: A pulse on `vec_ack_i` clears the pending request, so one pin pulse is serviced once.
- R10: If a request is set and cleared in the same cycle, the set wins and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| bus_addr_i | input | ADDR_W (8) | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W (8) | Write data |
| bus_rdata_o | output | DATA_W (8) | Read data for the current address |
| vec_ack_i | input | 1 | Vectoring acknowledge from exception processing |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach from the ports is a new active edge that reaches the latch in the same cycle as an acknowledge. The synchronizer hides the pin for two cycles, so the stimulus has to plan the pin pattern ahead. It drops the pin, raises it and drops it again on consecutive cycles, then raises the vectoring strobe exactly when the second falling edge reaches the detector. A second case is a mode or mask change made while the old level condition is still live. The vector table writes the control register while the pin sits at the active level and checks that the write cycle itself still sets the request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   // Field positions inside the status and control register
   localparam int unsigned BIT_RISE = 0;
   localparam int unsigned BIT_LVL  = 1;
   localparam int unsigned BIT_MASK = 2;
   localparam int unsigned BIT_REQ  = 6;

   typedef struct packed {
      logic mask;   // 1: output gated off
      logic lvl;    // 1: edge plus level
      logic rise;   // 1: rising edge / high level active
   } irq_ctrl_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect
   import ext_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sync_i,
   input  irq_ctrl_t ctrl_i,
   output logic      set_o
);
   logic prev_q;
   logic edge_hit;
   logic lvl_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_i;
   end

   always_comb begin
      if (ctrl_i.rise) begin
         edge_hit = sync_i & ~prev_q;
         lvl_hit  = sync_i;
      end else begin
         edge_hit = ~sync_i & prev_q;
         lvl_hit  = ~sync_i;
      end
   end

   assign set_o = edge_hit | (ctrl_i.lvl & lvl_hit);

   // R4: an edge is only reported when the synchronized pin actually moved
   assert_edge_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |-> (sync_i != $past(sync_i)));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic req_o
);
   logic req_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     req_q <= 1'b0;
      else if (set_i) req_q <= 1'b1;
      else if (clr_i) req_q <= 1'b0;
   end

   assign req_o = req_q;

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> req_q);
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !req_q);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(req_q));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned REG_ADDR    = 'h0F,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              vec_ack_i,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("ext_irq_ctrl: DATA_W must be at least 8");
      end
      if (ADDR_W < 32 && REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ext_irq_ctrl: REG_ADDR does not fit in ADDR_W");
      end
   endgenerate

   irq_ctrl_t ctrl_q;
   logic      sel;
   logic      wr_hit;
   logic      sw_ack;
   logic      pin_sync;
   logic      set;
   logic      req;
   logic      unused_wdata;

   assign sel    = (bus_addr_i == SEL_ADDR);
   assign wr_hit = bus_wr_i & sel;
   assign sw_ack = wr_hit & bus_wdata_i[BIT_REQ];
   assign unused_wdata = ^bus_wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_hit) begin
         ctrl_q.mask <= bus_wdata_i[BIT_MASK];
         ctrl_q.lvl  <= bus_wdata_i[BIT_LVL];
         ctrl_q.rise <= bus_wdata_i[BIT_RISE];
      end
   end

   irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   irq_detect u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (pin_sync),
      .ctrl_i (ctrl_q),
      .set_o  (set)
   );

   irq_req_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set),
      .clr_i (vec_ack_i | sw_ack),
      .req_o (req)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (sel) begin
         bus_rdata_o[BIT_REQ]  = req;
         bus_rdata_o[BIT_MASK] = ctrl_q.mask;
         bus_rdata_o[BIT_LVL]  = ctrl_q.lvl;
         bus_rdata_o[BIT_RISE] = ctrl_q.rise;
      end
   end

   assign irq_o = req & ~ctrl_q.mask;

   // R3: a register write takes effect in the following cycle
   assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (ctrl_q.mask == $past(bus_wdata_i[BIT_MASK])));
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b1;
   logic [7:0] addr = 8'h0F;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       vack = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ext_irq_ctrl i_ext_irq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .vec_ack_i   (vack),
      .irq_o       (irq)
   );

   typedef struct packed {
      logic       wr;
      logic [7:0] wd;
      logic       pin;
      logic       vack;
      logic [7:0] exp_rd;
      logic       exp_irq;
   } vec_t;

   // Expected values hold after the clock edge of the same row; address is 0x0F
   localparam vec_t VECS [31] = '{
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},  // 0  idle high, R4
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},  // 1  pin falls
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},  // 2
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h40, 1'b1},  // 3  R4 third edge
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h40, 1'b1},  // 4  held
      '{1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0},  // 5  R8 sw ack
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},  // 6  R5 low held
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},  // 7  rising, wrong edge
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},  // 8
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0},  // 9  R4 ignored
      '{1'b1, 8'h05, 1'b1, 1'b0, 8'h05, 1'b0},  // 10 R3 mask+rise
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h05, 1'b0},  // 11
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h05, 1'b0},  // 12
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h05, 1'b0},  // 13
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h05, 1'b0},  // 14
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h45, 1'b0},  // 15 R7 masked capture
      '{1'b1, 8'h01, 1'b1, 1'b0, 8'h41, 1'b1},  // 16 R7 unmask
      '{1'b0, 8'h00, 1'b1, 1'b1, 8'h01, 1'b0},  // 17 R9 vector ack
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0},  // 18 R9 once
      '{1'b1, 8'h03, 1'b1, 1'b0, 8'h03, 1'b0},  // 19 level high mode
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h43, 1'b1},  // 20 R6 level sets
      '{1'b1, 8'h43, 1'b1, 1'b0, 8'h43, 1'b1},  // 21 R6 sw ack loses
      '{1'b0, 8'h00, 1'b1, 1'b1, 8'h43, 1'b1},  // 22 R6 vec ack loses
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h43, 1'b1},  // 23
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h43, 1'b1},  // 24 level still seen
      '{1'b1, 8'h43, 1'b0, 1'b0, 8'h03, 1'b0},  // 25 R6 inactive, ack works
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h03, 1'b0},  // 26
      '{1'b1, 8'h02, 1'b0, 1'b0, 8'h02, 1'b0},  // 27 level low mode
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h42, 1'b1},  // 28 R6 low level sets
      '{1'b1, 8'h40, 1'b0, 1'b0, 8'h40, 1'b1},  // 29 R10 old mode sets this cycle
      '{1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 1'b0}   // 30 R8 edge mode, ack clears
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic p, input logic va);
      addr = a; wr = w; wdata = d; pin = p; vack = va;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; vack = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 state under reset
      check8("R1 rdata in reset", rdata, 8'h00);
      check1("R1 irq in reset", irq, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) step(8'h0F, 1'b0, 8'h00, 1'b1, 1'b0);
      check8("R1 rdata after reset", rdata, 8'h00);
      check1("R1 irq after reset", irq, 1'b0);

      for (int i = 0; i < 31; i++) begin
         step(8'h0F, VECS[i].wr, VECS[i].wd, VECS[i].pin, VECS[i].vack);
         check8($sformatf("vector %0d rdata (R3..R10)", i), rdata, VECS[i].exp_rd);
         check1($sformatf("vector %0d irq (R4..R10)", i), irq, VECS[i].exp_irq);
      end

      // Directed: falling edge only mode, pin high to settle
      for (int i = 0; i < 3; i++) step(8'h0F, 1'b0, 8'h00, 1'b1, 1'b0);
      check8("R5 settled", rdata, 8'h00);
      step(8'h0F, 1'b0, 8'h00, 1'b0, 1'b0);   // d0
      step(8'h0F, 1'b0, 8'h00, 1'b1, 1'b0);   // d1
      step(8'h0F, 1'b0, 8'h00, 1'b0, 1'b0);   // d2: first edge latched
      check8("R4 pulse latched", rdata, 8'h40);
      // R2: write with ack and controls at a foreign address
      step(8'h0E, 1'b1, 8'h47, 1'b0, 1'b0);   // d3
      check8("R2 foreign read", rdata, 8'h00);
      addr = 8'h0F;
      #1;
      check8("R2 foreign write ignored", rdata, 8'h40);
      check1("R2 irq kept", irq, 1'b1);
      step(8'h0F, 1'b0, 8'h00, 1'b0, 1'b1);   // d4: second edge meets ack
      check1("R10 edge beats ack", irq, 1'b1);
      check8("R10 req kept", rdata, 8'h40);
      step(8'h0F, 1'b0, 8'h00, 1'b0, 1'b1);   // d5
      check1("R9 ack clears", irq, 1'b0);
      // R8: writing 0 at bit 6 keeps a pending request
      step(8'h0F, 1'b0, 8'h00, 1'b1, 1'b0);
      step(8'h0F, 1'b0, 8'h00, 1'b0, 1'b0);
      step(8'h0F, 1'b0, 8'h00, 1'b0, 1'b0);
      step(8'h0F, 1'b0, 8'h00, 1'b0, 1'b0);
      check8("R4 new pulse", rdata, 8'h40);
      step(8'h0F, 1'b1, 8'h00, 1'b0, 1'b0);
      check8("R8 zero write keeps req", rdata, 8'h40);
      // R1: reset clears a pending request and the controls
      step(8'h0F, 1'b1, 8'h07, 1'b0, 1'b0);
      check8("R3 all controls", rdata, 8'h47);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check8("R1 reset clears", rdata, 8'h00);
      check1("R1 reset irq", irq, 1'b0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule